// File: doc/BRIEF.md
# Non-Power-of-Two Address Mirror Unit

This unit folds a bus address into the offset range of a memory whose size does not have to be a power of two. The memory is taken to repeat the way a decoder built from power-of-two chunks repeats it. A size of three, for example, is decoded as a two-word chunk followed by a one-word chunk, and the address is folded into that shape. A plain AND with the size minus one does not give this result.

A request is one address and one size, presented together with a one-cycle start strobe. The unit then works one address bit per cycle. A scan mask starts at the top bit of the 28-bit bus and walks downward. At each set address bit it strips that bit from the address, and it moves the chunk base up when the remaining size is larger than the chunk. When the address falls below the remaining size, the unit adds the base and the remaining address, presents that sum as the result and raises a done pulse.

Top module: `mirror_fold`

## Requirements
- R1: When the size is zero, the result is zero.
- R2: When the address is already below a nonzero size, the result equals the address.
- R3: When the size is a power of two, the result equals the address ANDed with the size minus one.
- R4: For any size, the result equals the chunk-folding function. Starting with base zero and a mask at bit 27, and while the address is not below the size, the function moves the mask down to the highest set address bit and subtracts that bit from the address. If the size exceeds the mask, the function also takes the mask from the size and adds it to the base. It then shifts the mask right by one. The result is the base plus the remaining address.
- R5: For a nonzero size, the result is always below the size.
- R6: Busy is high in the cycle after a start is accepted and stays high until the result is ready. Done is then high for exactly one cycle, with busy low in that cycle.
- R7: A start raised while busy is high is ignored. The result belongs to the request that was accepted.
- R8: Done is seen no later than AW+2 rising edges after the edge that accepted the start, counting that edge. The unit spends at most AW+1 cycles busy.
- R9: After reset, busy, done and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only while idle |
| addr_i | input | AW | Address to fold |
| size_i | input | AW | Memory size, in addressable units |
| busy | output | 1 | High while a fold is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | AW | Folded offset |

## Verification
The bench goes after the sizes where chunk folding and masking disagree, such as 3, 5 and all-ones. A design that masked with the size minus one would give out-of-range offsets for these sizes, or offsets that differ from the chunk layout. It also drives a zero size, which a design without the special case would loop on or answer with the raw address. It drives addresses already in range, which a design that always folded would corrupt. An all-ones address with a tiny size forces the full 28-step scan, which exposes an off-by-one in the mask walk or the latency bound. A second start is raised mid-fold, and a design that reloaded its registers would return the result for the wrong request.

// File: rtl/mirror_fold.sv
module mirror_fold #(
  parameter int AW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] size_i,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] result
);
  localparam int CW = $clog2(AW + 2);
  localparam logic [AW-1:0] TOP = {1'b1, {(AW-1){1'b0}}};

  logic [AW-1:0] a_q, s_q, base_q, mask_q, orig_q;
  logic [CW-1:0] cnt_q;
  logic          hit, fin;

  assign hit = |(a_q & mask_q);
  assign fin = (s_q == '0) || (a_q < s_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      a_q    <= '0;
      s_q    <= '0;
      base_q <= '0;
      mask_q <= '0;
      orig_q <= '0;
      cnt_q  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          a_q    <= addr_i;
          s_q    <= size_i;
          orig_q <= size_i;
          base_q <= '0;
          mask_q <= TOP;
          cnt_q  <= '0;
          busy   <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (fin) begin
          result <= (s_q == '0) ? '0 : base_q + a_q;
          done   <= 1'b1;
          busy   <= 1'b0;
        end else begin
          if (hit) begin
            a_q <= a_q - mask_q;
            if (s_q > mask_q) begin
              s_q    <= s_q - mask_q;
              base_q <= base_q + mask_q;
            end
          end
          mask_q <= mask_q >> 1;
        end
      end
    end
  end

  AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && orig_q == '0) |-> result == '0); // R1
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && orig_q != '0) |-> result < orig_q); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(orig_q)); // R7
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q <= CW'(AW)); // R8
  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot0(mask_q)); // R4
endmodule

// File: tb/mirror_fold_tb.sv
`timescale 1ns/1ps
module mirror_fold_tb_top;
  localparam int AW = 28;
  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] addr_i = '0, size_i = '0;
  logic busy, done;
  logic [AW-1:0] result;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  mirror_fold #(.AW(AW)) dut_i (.clk(clk), .rst_n(rst_n), .start(start),
    .addr_i(addr_i), .size_i(size_i), .busy(busy), .done(done), .result(result));

  function automatic logic [AW-1:0] model(input logic [AW-1:0] a, input logic [AW-1:0] s);
    longint unsigned ad, sz, base, m;
    ad = a; sz = s; base = 0; m = 64'd1 << (AW-1);
    if (sz == 0) return '0;
    while (ad >= sz) begin
      while ((ad & m) == 0) m = m >> 1;
      ad = ad - m;
      if (sz > m) begin sz = sz - m; base = base + m; end
      m = m >> 1;
    end
    return AW'(base + ad);
  endfunction

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [AW-1:0] a, input logic [AW-1:0] s, input string req, input bit disturb);
    int n;
    logic [AW-1:0] exp;
    exp = model(a, s);
    @(negedge clk);
    start = 1; addr_i = a; size_i = s;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R6 busy after start", AW'(busy), 1);
    if (disturb) begin start = 1; addr_i = ~a; size_i = s ^ 28'h1; end
    n = 1;
    while (done !== 1'b1 && n < 40) begin
      if (disturb && n == 3) start = 0;
      @(negedge clk);
      n++;
    end
    start = 0;
    check(n <= AW + 2, "R8 latency", AW'(n), AW + 2);
    check(busy === 1'b0, "R6 busy low with done", AW'(busy), 0);
    check(result === exp, req, result, exp);
    if (s != 0) check(result < s, "R5 below size", result, s);
    @(negedge clk);
    check(done === 1'b0, "R6 done one cycle", AW'(done), 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] a, s;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && result === '0, "R9 reset state", result, 0);
    rst_n = 1;
    run_case(28'h1234, 28'h0, "R1 zero size", 0);
    check(result === '0, "R1 zero result", result, 0);
    run_case(28'h5, 28'hA, "R2 in range", 0);
    check(result === 28'h5, "R2 passthrough", result, 28'h5);
    run_case(28'h7654321, 28'h100000, "R3 pow2 size", 0);
    check(result === 28'h54321, "R3 masked", result, 28'h54321);
    run_case(28'h7, 28'h5, "R4 size 5", 0);
    check(result === 28'h4, "R4 size 5 value", result, 28'h4);
    run_case(28'h3, 28'h3, "R4 size 3", 0);
    check(result === 28'h2, "R4 size 3 value", result, 28'h2);
    run_case(28'hFFFFFFF, 28'h3, "R4 R8 full scan", 0);
    run_case(28'hFFFFFFF, 28'hFFFFFFF, "R4 max size", 0);
    run_case(28'hFFFFFFF, 28'h1, "R4 size 1", 0);
    check(result === '0, "R4 size 1 value", result, 0);
    run_case(28'hABCDEF1, 28'h3, "R7 start ignored while busy", 1);
    for (int i = 0; i < 300; i++) begin
      a = AW'($urandom);
      case (i % 4)
        0: s = AW'($urandom);
        1: s = AW'(1) << ($urandom % AW);
        2: s = AW'($urandom % 64);
        default: s = AW'($urandom) >> ($urandom % AW);
      endcase
      run_case(a, s, (i % 4 == 1) ? "R3 random pow2" : "R4 random", i % 37 == 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule